// File: doc/BRIEF.md
# Pseudo dual-edge storage register

This block keeps a data word that is refreshed on both the rising and the falling edge of a single clock. The target fabric has only flops that trigger on one edge, so the register uses two banks of ordinary flops. One bank samples on the rising edge and the other on the falling edge. The visible output is the bitwise XOR of the two banks. Each bank computes its next value from the merged output and the other bank's contents. As a result, the output always shows the data present at the most recent enabled edge of either polarity.

An enable input freezes the stored word. When the enable is low at an edge, the bank that triggers reloads a value that leaves the XOR unchanged. An asynchronous active-high reset clears both banks at once, so the output becomes zero without waiting for a clock edge.

The XOR on the output and the feedback into both banks lengthen the output delay and move the setup and hold windows. The register therefore suits only paths that can tolerate this.

Top module: `dual_edge_reg`

## Requirements
- R1: On a rising clock edge with `en` high, `q` takes the value `d` had at that edge, and keeps it until the next edge.
- R2: On a falling clock edge with `en` high, `q` takes the value `d` had at that edge, and keeps it until the next edge.
- R3: Between two clock edges, `q` does not change when `d` changes.
- R4: On an edge of either polarity with `en` low, `q` keeps the value it had before that edge.
- R5: While `rst` is high, `q` is all zeros. `q` clears as soon as `rst` rises, without a clock edge, and stays zero across edges of both polarities while `rst` is held.
- R6: Each of the `WIDTH` bits is stored independently. Alternating bit patterns loaded on opposite edges come out unchanged, bit for bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both edges are active |
| rst | input | 1 | Asynchronous reset, active high |
| en | input | 1 | Load enable, sampled at each edge |
| d | input | WIDTH | Data to store |
| q | output | WIDTH | Stored word (XOR of the two banks) |

## Verification
The bench provokes two situations. In the first, one edge stores data while the opposite edge of the same clock period holds it, because `en` is low at that edge. Here the holding bank has to recompute its contents from the other bank's fresh value, and the check is that `q` still equals the earlier-stored word after the holding edge. In the second, reset is raised in the middle of the high phase, just after a rising-edge load. It is then held across an enabled falling edge that presents all-ones data. The check is that `q` is zero both right after `rst` rises and after that falling edge.

// File: rtl/dual_edge_pkg.sv
package dual_edge_pkg;

    // Selects which clock edge a storage bank triggers on.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;

endpackage

// File: rtl/dual_edge_bank.sv
module dual_edge_bank
    import dual_edge_pkg::*;
#(
    parameter int        WIDTH = 8,
    parameter edge_pol_e POL   = EDGE_RISE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    input  logic [WIDTH-1:0] merged,
    input  logic [WIDTH-1:0] partner,
    output logic [WIDTH-1:0] bank
);

    logic [WIDTH-1:0] target;
    logic [WIDTH-1:0] next_bank;

    // The word the output should show after this edge; the bank holds
    // whatever makes the XOR with the partner bank equal to it.
    assign target    = en ? d : merged;
    assign next_bank = target ^ partner;

    generate
        if (POL == EDGE_RISE) begin : g_rise
            always_ff @(posedge clk or posedge rst) begin
                if (rst) bank <= '0;
                else     bank <= next_bank;
            end

            assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
                !en |=> $stable(bank));
            assert_reset_R5: assert property (@(negedge clk)
                rst |-> (bank == '0));
        end else begin : g_fall
            always_ff @(negedge clk or posedge rst) begin
                if (rst) bank <= '0;
                else     bank <= next_bank;
            end

            assert_hold_R4: assert property (@(negedge clk) disable iff (rst)
                !en |=> $stable(bank));
            assert_reset_R5: assert property (@(posedge clk)
                rst |-> (bank == '0));
        end
    endgenerate

endmodule

// File: rtl/dual_edge_merge.sv
module dual_edge_merge #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] rise_bank,
    input  logic [WIDTH-1:0] fall_bank,
    output logic [WIDTH-1:0] merged
);

    assign merged = rise_bank ^ fall_bank;

endmodule

// File: rtl/dual_edge_reg.sv
module dual_edge_reg
    import dual_edge_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] rise_bank;
    logic [WIDTH-1:0] fall_bank;
    logic [WIDTH-1:0] merged;

    dual_edge_bank #(.WIDTH(WIDTH), .POL(EDGE_RISE)) u_rise (
        .clk(clk), .rst(rst), .en(en), .d(d),
        .merged(merged), .partner(fall_bank), .bank(rise_bank)
    );

    dual_edge_bank #(.WIDTH(WIDTH), .POL(EDGE_FALL)) u_fall (
        .clk(clk), .rst(rst), .en(en), .d(d),
        .merged(merged), .partner(rise_bank), .bank(fall_bank)
    );

    dual_edge_merge #(.WIDTH(WIDTH)) u_merge (
        .rise_bank(rise_bank), .fall_bank(fall_bank), .merged(merged)
    );

    assign q = merged;

    // Shadow copies of the stimulus seen at each edge, used only to check
    // that the output presented half a period later matches it.
    logic             rise_en_seen, fall_en_seen;
    logic [WIDTH-1:0] rise_d_seen,  fall_d_seen;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            rise_en_seen <= 1'b0;
            rise_d_seen  <= '0;
        end else begin
            rise_en_seen <= en;
            rise_d_seen  <= d;
        end
    end

    always_ff @(negedge clk or posedge rst) begin
        if (rst) begin
            fall_en_seen <= 1'b0;
            fall_d_seen  <= '0;
        end else begin
            fall_en_seen <= en;
            fall_d_seen  <= d;
        end
    end

    assert_rise_load_R1: assert property (@(negedge clk) disable iff (rst)
        rise_en_seen |-> (q == rise_d_seen));
    assert_fall_load_R2: assert property (@(posedge clk) disable iff (rst)
        fall_en_seen |-> (q == fall_d_seen));

endmodule

// File: tb/test_dual_edge_reg.sv
module test_dual_edge_reg;

    localparam int W = 8;
    localparam int N = 16;

    // Each entry: enable, data, expected q after the edge.
    // Even entries apply at a rising edge, odd entries at a falling edge.
    typedef struct packed {
        logic         en;
        logic [W-1:0] d;
        logic [W-1:0] exp;
    } vec_t;

    localparam vec_t TBL [N] = '{
        '{1'b1, 8'hA5, 8'hA5}, '{1'b1, 8'h3C, 8'h3C},
        '{1'b1, 8'hFF, 8'hFF}, '{1'b1, 8'h00, 8'h00},
        '{1'b0, 8'h77, 8'h00}, '{1'b1, 8'h81, 8'h81},
        '{1'b1, 8'h81, 8'h81}, '{1'b0, 8'h12, 8'h81},
        '{1'b0, 8'h34, 8'h81}, '{1'b1, 8'h5A, 8'h5A},
        '{1'b1, 8'hA5, 8'hA5}, '{1'b1, 8'hA5, 8'hA5},
        '{1'b1, 8'h0F, 8'h0F}, '{1'b0, 8'hF0, 8'h0F},
        '{1'b1, 8'hF0, 8'hF0}, '{1'b1, 8'hC3, 8'hC3}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b0;
    logic         en  = 1'b0;
    logic [W-1:0] d   = '0;
    logic [W-1:0] q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    dual_edge_reg #(.WIDTH(W)) i_dual_edge_reg (
        .clk(clk), .rst(rst), .en(en), .d(d), .q(q)
    );

    task automatic check(input string req, input logic [W-1:0] exp);
        checks++;
        if (q !== exp) begin
            fails++;
            $display("FAIL %s: q=%h expected=%h at %0t", req, q, exp, $time);
        end
    endtask

    initial begin
        #1 rst = 1'b1;
        #2 check("R5 reset clears output", '0);
        #19 rst = 1'b0;                       // t=22, between fall 20 and rise 25

        for (int i = 0; i < N; i++) begin
            en = TBL[i].en;
            d  = TBL[i].d;
            if (i % 2 == 0) @(posedge clk); else @(negedge clk);
            #1;
            if (!TBL[i].en)      check("R4 disabled edge holds", TBL[i].exp);
            else if (i % 2 == 0) check("R1 rising edge load", TBL[i].exp);
            else                 check("R2 falling edge load", TBL[i].exp);
            #1 d = ~d;
            #1 check("R3 stable between edges", TBL[i].exp);
        end

        // R6: alternating patterns on opposite edges
        en = 1'b1; d = 8'h55;
        @(posedge clk); #1 check("R6 bit pattern 55 on rise", 8'h55);
        #2 d = 8'hAA;
        @(negedge clk); #1 check("R6 bit pattern AA on fall", 8'hAA);

        // R5: reset raised mid high phase, held across an enabled fall
        #2 d = 8'h3E;
        @(posedge clk); #1 check("R1 load before reset", 8'h3E);
        #1 rst = 1'b1;
        #1 check("R5 async clear without edge", '0);
        d = 8'hFF;
        @(negedge clk); #1 check("R5 held across enabled fall", '0);
        #1 rst = 1'b0;
        d = 8'h5A;
        @(posedge clk); #1 check("R1 first load after reset", 8'h5A);
        #2 en = 1'b0; d = 8'h00;
        @(negedge clk); #1 check("R4 hold after reset release", 8'h5A);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: q=%h expected=run completion", q);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule